// File: doc/BRIEF.md
# Floppy sector command sequencer

This block is the command engine of a single-density floppy controller. A host issues a command through a small register interface. It then moves parameter and data bytes one at a time through a data port, paced by a transfer-request flag. Commands fall into three groups: sector read and write (normal or deleted-data), buffer fill and buffer empty, and housekeeping (init, no-op, read back the last error code). The sequencer checks the drive's state and the sector parameters. It waits a seek time, copies one sector between an internal sector buffer and an on-chip sector store, and then raises done with an 8-bit completion code.

For a read or write, the host sends the sector number and then the track number. The sequencer loads a seek timer with the per-track step time multiplied by the distance from the drive's current track. After the timer runs out it checks, in fixed priority, for missing media, a bad track, a bad sector and write protection. If all checks pass, it copies the sector one byte per cycle. The store address is ((drive*TRACKS + track)*SECTORS + sector-1)*BYTES. Reset starts the init routine automatically.

States and transitions: IDLE goes to FILL, EMPTY, SECT, INIT, NOP or ECODE when a command is accepted. FILL returns to IDLE after the last byte. EMPTY alternates with EMPTY_W (waiting for the host to read) until the buffer is drained, then goes to IDLE. SECT goes to TRK on the first byte, and TRK goes to SEEK on the second byte. SEEK goes to CHECK when the timer expires. CHECK goes to IDLE on a fault, or otherwise to COPY. INIT goes to COPY, or to IDLE if drive 0 has no media. COPY returns to IDLE after the last byte. NOP and ECODE return to IDLE after one cycle.

Top module: `sector_seq`

## Requirements
- R1: Reset runs init. Drive 0 is placed on track 1 and drive 1 on track 0, and drive 0 track 1 sector 1 is copied into the buffer. Then done and st_init_done are set, with code 0, or octal 020 (0x10) if drive 1 has no media. If drive 0 has no media, init ends at once with code octal 010 (0x08).
- R2: cmd_fn encodes the commands as follows: 0 fill, 1 empty, 2 write, 3 read, 4 init, 5 no-op, 6 write deleted data, 7 read error code.
- R3: After a read or write command, xreq is high while the sector byte is awaited and again while the track byte is awaited. It drops once the track byte has been written. The first byte written is the sector and the second is the track.
- R4: Between the track byte and the check, the seek takes STEP_CYC × |track − current track| extra cycles. A drive's current track changes only when media is present and the track passes its range check, even if the sector then fails.
- R5: A track number of TRACKS or more ends the command with code octal 040 (0x20) and no transfer.
- R6: Sector 0, or a sector above SECTORS, ends the command with code octal 070 (0x38). Sectors 1 to SECTORS are accepted.
- R7: A drive without media ends the command with code octal 110 (0x48). A write to a write-protected drive ends with code octal 100 (0x40), sets st_wlock and leaves the store unchanged.
- R8: A successful read or write ends with code 0. A write-deleted command also sets st_deleted. All status bits clear when a command is accepted.
- R9: Fill takes BYTES host bytes into buffer positions 0 upward. xreq stays high until the last byte, and done rises together with the fall of xreq.
- R10: Empty presents buffer bytes 0 upward on data_out with xreq high, one per host read. Done follows the last read.
- R11: Read-error-code places the held code on data_out and leaves err_code unchanged.
- R12: done stays high until a command is accepted. A command written while the sequencer is busy is ignored.
- R13: The init command behaves exactly as the init that reset starts.
- R14: Every (drive, track, sector) maps to its own store location, so data written to each of them reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts init |
| cmd_wr | input | 1 | Command write strobe |
| cmd_fn | input | 3 | Command code |
| cmd_drv | input | 1 | Drive select |
| data_wr | input | 1 | Host writes the data port |
| data_in | input | 8 | Byte written by the host |
| data_rd | input | 1 | Host has read the data port |
| data_out | output | 8 | Byte presented to the host |
| xreq | output | 1 | Transfer request |
| done | output | 1 | Command complete |
| err_code | output | 8 | Completion code of the last command |
| st_init_done | output | 1 | Last command was an init |
| st_deleted | output | 1 | Deleted-data mark written |
| st_wlock | output | 1 | Write refused by protection |
| drv_media | input | 2 | Media present, one bit per drive |
| drv_wprot | input | 2 | Write protect, one bit per drive |

## Verification
A wrong current-track value shows up only in the seek time of the next read or write to that drive. The bench therefore compares completion latencies against a zero-distance baseline. An address or index error corrupts stored data silently. It appears only when the affected sector is read back and emptied, so every sector of both drives is written with a distinct pattern before any of them is read back. A fault-priority or status slip shows on err_code and the status bits in the same cycle that done rises.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        FN_FILL  = 3'd0,
        FN_EMPTY = 3'd1,
        FN_WRITE = 3'd2,
        FN_READ  = 3'd3,
        FN_INIT  = 3'd4,
        FN_NOP   = 3'd5,
        FN_WRDEL = 3'd6,
        FN_ECODE = 3'd7
    } fn_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INIT,
        S_FILL,
        S_EMPTY,
        S_EMPTY_W,
        S_SECT,
        S_TRK,
        S_SEEK,
        S_CHECK,
        S_COPY,
        S_NOP,
        S_ECODE
    } st_t;

    localparam logic [7:0] EC_OK      = 8'o000;
    localparam logic [7:0] EC_INIT_D0 = 8'o010;
    localparam logic [7:0] EC_NO_D1   = 8'o020;
    localparam logic [7:0] EC_TRACK   = 8'o040;
    localparam logic [7:0] EC_SECTOR  = 8'o070;
    localparam logic [7:0] EC_WLOCK   = 8'o100;
    localparam logic [7:0] EC_NOMEDIA = 8'o110;

endpackage

// File: rtl/seek_timer.sv
module seek_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sector_buffer.sv
module sector_buffer #(
    parameter int BYTES = 16,
    localparam int B_W = $clog2(BYTES)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [B_W-1:0] waddr,
    input  logic [7:0]     wdata,
    input  logic [B_W-1:0] raddr,
    output logic [7:0]     rdata
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sector_store.sv
module sector_store #(
    parameter int DEPTH = 1024,
    localparam int A_W = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [A_W-1:0] addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/sector_seq.sv
module sector_seq
    import seq_pkg::*;
#(
    parameter int TRACKS   = 8,
    parameter int SECTORS  = 4,
    parameter int BYTES    = 16,
    parameter int STEP_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [2:0] cmd_fn,
    input  logic       cmd_drv,
    input  logic       data_wr,
    input  logic [7:0] data_in,
    input  logic       data_rd,
    output logic [7:0] data_out,
    output logic       xreq,
    output logic       done,
    output logic [7:0] err_code,
    output logic       st_init_done,
    output logic       st_deleted,
    output logic       st_wlock,
    input  logic [1:0] drv_media,
    input  logic [1:0] drv_wprot
);
    localparam int DEPTH = 2 * TRACKS * SECTORS * BYTES;
    localparam int SA_W  = $clog2(DEPTH);
    localparam int B_W   = $clog2(BYTES);
    localparam int IDX_W = $clog2(BYTES + 1);
    localparam int CNT_W = $clog2(256 * STEP_CYC);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(BYTES);

    st_t              state, nxt;
    fn_t              fn_q;
    logic             drv_q;
    logic [7:0]       sec_q, trk_q;
    logic [7:0]       cur_trk [2];
    logic [IDX_W-1:0] bidx;
    logic [SA_W-1:0]  base_q, base_calc;
    logic             copy_rd, is_init;

    logic             fin;
    logic [7:0]       fin_code;
    logic             no_media, bad_trk, bad_sec, is_wr_fn, wlock_hit;
    logic [7:0]       cur_sel, trk_dist;
    logic             seek_load, seek_exp;
    logic [CNT_W-1:0] seek_val;

    logic             buf_we;
    logic [7:0]       buf_wdata, buf_rdata;
    logic             st_we;
    logic [SA_W-1:0]  st_addr;
    logic [7:0]       st_rdata;

    // parameter checks and address of the requested sector
    assign is_wr_fn  = (fn_q == FN_WRITE) || (fn_q == FN_WRDEL);
    assign no_media  = !drv_media[drv_q];
    assign bad_trk   = (32'(trk_q) >= TRACKS);
    assign bad_sec   = (sec_q == 8'd0) || (32'(sec_q) > SECTORS);
    assign wlock_hit = is_wr_fn && drv_wprot[drv_q];
    assign base_calc = SA_W'(((32'(drv_q) * TRACKS + 32'(trk_q)) * SECTORS
                              + 32'(sec_q) - 1) * BYTES);

    // seek distance from the drive's present track
    assign cur_sel   = cur_trk[drv_q];
    assign trk_dist  = (data_in > cur_sel) ? (data_in - cur_sel) : (cur_sel - data_in);
    assign seek_load = (state == S_TRK) && data_wr;
    assign seek_val  = CNT_W'(32'(trk_dist) * STEP_CYC);

    seek_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seek_load),
        .load_val (seek_val),
        .expired  (seek_exp)
    );

    assign buf_we    = ((state == S_FILL) && data_wr) || ((state == S_COPY) && copy_rd);
    assign buf_wdata = (state == S_FILL) ? data_in : st_rdata;

    sector_buffer #(.BYTES(BYTES)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (bidx[B_W-1:0]),
        .wdata (buf_wdata),
        .raddr (bidx[B_W-1:0]),
        .rdata (buf_rdata)
    );

    assign st_we   = (state == S_COPY) && !copy_rd;
    assign st_addr = base_q + SA_W'(bidx);

    sector_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (st_we),
        .addr  (st_addr),
        .wdata (buf_rdata),
        .rdata (st_rdata)
    );

    // next state and completion decision
    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_code = EC_OK;
        unique case (state)
            S_IDLE: begin
                if (cmd_wr) begin
                    unique case (fn_t'(cmd_fn))
                        FN_FILL:  nxt = S_FILL;
                        FN_EMPTY: nxt = S_EMPTY;
                        FN_WRITE, FN_READ, FN_WRDEL: nxt = S_SECT;
                        FN_INIT:  nxt = S_INIT;
                        FN_NOP:   nxt = S_NOP;
                        FN_ECODE: nxt = S_ECODE;
                        default:  nxt = S_IDLE;
                    endcase
                end
            end
            S_INIT: begin
                if (!drv_media[0]) begin
                    fin      = 1'b1;
                    fin_code = EC_INIT_D0;
                    nxt      = S_IDLE;
                end else begin
                    nxt = S_COPY;
                end
            end
            S_FILL: begin
                if (data_wr && (bidx == IDX_LAST)) begin
                    fin = 1'b1;
                    nxt = S_IDLE;
                end
            end
            S_EMPTY: begin
                if (bidx == IDX_END) begin
                    fin = 1'b1;
                    nxt = S_IDLE;
                end else begin
                    nxt = S_EMPTY_W;
                end
            end
            S_EMPTY_W: if (data_rd) nxt = S_EMPTY;
            S_SECT:    if (data_wr) nxt = S_TRK;
            S_TRK:     if (data_wr) nxt = S_SEEK;
            S_SEEK:    if (seek_exp) nxt = S_CHECK;
            S_CHECK: begin
                nxt = S_IDLE;
                fin = 1'b1;
                if (no_media)       fin_code = EC_NOMEDIA;
                else if (bad_trk)   fin_code = EC_TRACK;
                else if (bad_sec)   fin_code = EC_SECTOR;
                else if (wlock_hit) fin_code = EC_WLOCK;
                else begin
                    fin = 1'b0;
                    nxt = S_COPY;
                end
            end
            S_COPY: begin
                if (bidx == IDX_LAST) begin
                    fin      = 1'b1;
                    fin_code = (is_init && !drv_media[1]) ? EC_NO_D1 : EC_OK;
                    nxt      = S_IDLE;
                end
            end
            S_NOP: begin
                fin = 1'b1;
                nxt = S_IDLE;
            end
            S_ECODE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_INIT;
        else        state <= nxt;
    end

    // host-visible outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done         <= 1'b0;
            xreq         <= 1'b0;
            err_code     <= EC_OK;
            data_out     <= 8'd0;
            st_init_done <= 1'b0;
            st_deleted   <= 1'b0;
            st_wlock     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_wr) begin
                        done         <= 1'b0;
                        st_init_done <= 1'b0;
                        st_deleted   <= 1'b0;
                        st_wlock     <= 1'b0;
                        xreq <= (fn_t'(cmd_fn) == FN_FILL)  || (fn_t'(cmd_fn) == FN_WRITE) ||
                                (fn_t'(cmd_fn) == FN_READ)  || (fn_t'(cmd_fn) == FN_WRDEL);
                    end
                end
                S_EMPTY: begin
                    if (bidx != IDX_END) begin
                        data_out <= buf_rdata;
                        xreq     <= 1'b1;
                    end
                end
                S_EMPTY_W: if (data_rd) xreq <= 1'b0;
                S_TRK:     if (data_wr) xreq <= 1'b0;
                S_CHECK: begin
                    if (!no_media && !bad_trk && !bad_sec) begin
                        if (fn_q == FN_WRDEL) st_deleted <= 1'b1;
                        if (wlock_hit)        st_wlock   <= 1'b1;
                    end
                end
                S_ECODE: begin
                    data_out <= err_code;
                    done     <= 1'b1;
                end
                default: ;
            endcase
            if (fin) begin
                done     <= 1'b1;
                xreq     <= 1'b0;
                err_code <= fin_code;
                if ((state == S_INIT) || ((state == S_COPY) && is_init)) begin
                    st_init_done <= 1'b1;
                end
            end
        end
    end

    // command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q       <= FN_NOP;
            drv_q      <= 1'b0;
            sec_q      <= 8'd0;
            trk_q      <= 8'd0;
            cur_trk[0] <= 8'd0;
            cur_trk[1] <= 8'd0;
            bidx       <= '0;
            base_q     <= '0;
            copy_rd    <= 1'b0;
            is_init    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_wr) begin
                        fn_q  <= fn_t'(cmd_fn);
                        drv_q <= cmd_drv;
                        bidx  <= '0;
                    end
                end
                S_INIT: begin
                    cur_trk[0] <= 8'd1;
                    cur_trk[1] <= 8'd0;
                    copy_rd    <= 1'b1;
                    is_init    <= 1'b1;
                    base_q     <= SA_W'(SECTORS * BYTES);
                    bidx       <= '0;
                end
                S_FILL:  if (data_wr && (bidx != IDX_LAST)) bidx <= bidx + IDX_W'(1);
                S_EMPTY: if (bidx != IDX_END) bidx <= bidx + IDX_W'(1);
                S_SECT:  if (data_wr) sec_q <= data_in;
                S_TRK:   if (data_wr) trk_q <= data_in;
                S_CHECK: begin
                    if (!no_media && !bad_trk) cur_trk[drv_q] <= trk_q;
                    copy_rd <= (fn_q == FN_READ);
                    is_init <= 1'b0;
                    base_q  <= base_calc;
                    bidx    <= '0;
                end
                S_COPY:  bidx <= bidx + IDX_W'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [2:0] cmd_fn,
    input logic       done,
    input logic       xreq,
    input logic [7:0] err_code,
    input logic       st_init_done,
    input logic       st_wlock
);
    p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cmd_wr |=> done);

    p_done_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done && cmd_wr |=> !done);

    p_no_req_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !xreq);

    p_code_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && cmd_wr && (cmd_fn == 3'd7) |=> $stable(err_code));

    p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 8'o000 || err_code == 8'o010 || err_code == 8'o020 ||
                  err_code == 8'o040 || err_code == 8'o070 || err_code == 8'o100 ||
                  err_code == 8'o110));

    p_wlock_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && st_wlock |-> err_code == 8'o100);

    p_init_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && st_init_done |-> (err_code == 8'o000 || err_code == 8'o010 ||
                                  err_code == 8'o020));
endmodule

bind sector_seq seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_fn       (cmd_fn),
    .done         (done),
    .xreq         (xreq),
    .err_code     (err_code),
    .st_init_done (st_init_done),
    .st_wlock     (st_wlock)
);

// File: tb/sim_sector_seq.sv
module sim_sector_seq;
    import seq_pkg::*;

    localparam int TRACKS = 8, SECTORS = 4, BYTES = 16, STEP = 3;

    logic       clk = 1'b0;
    logic       rst_n, cmd_wr, cmd_drv, data_wr, data_rd;
    logic [2:0] cmd_fn;
    logic [7:0] data_in, data_out, err_code;
    logic       xreq, done, st_init_done, st_deleted, st_wlock;
    logic [1:0] drv_media, drv_wprot;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    sector_seq #(.TRACKS(TRACKS), .SECTORS(SECTORS), .BYTES(BYTES), .STEP_CYC(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_fn(cmd_fn), .cmd_drv(cmd_drv),
        .data_wr(data_wr), .data_in(data_in), .data_rd(data_rd), .data_out(data_out),
        .xreq(xreq), .done(done), .err_code(err_code), .st_init_done(st_init_done),
        .st_deleted(st_deleted), .st_wlock(st_wlock), .drv_media(drv_media),
        .drv_wprot(drv_wprot)
    );

    function automatic logic [7:0] pat(int d, int t, int s, int i, int salt);
        return 8'((d * 97 + t * 31 + s * 7 + i * 13 + salt) & 255);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic issue(input fn_t fn, input logic drv);
        cmd_fn  = fn;
        cmd_drv = drv;
        cmd_wr  = 1'b1;
        @(negedge clk);
        cmd_wr  = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        while (!xreq) @(negedge clk);
        data_in = b;
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b);
        while (!xreq) @(negedge clk);
        b = data_out;
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic fill_pat(input int d, input int t, input int s, input int salt);
        int c;
        issue(FN_FILL, 1'b0);
        for (int i = 0; i < BYTES; i++) put_byte(pat(d, t, s, i, salt));
        wait_done(c);
    endtask

    task automatic sector_rw(input fn_t fn, input int d, input int s, input int t, output int cyc);
        issue(fn, d[0]);
        put_byte(8'(s));
        put_byte(8'(t));
        wait_done(cyc);
    endtask

    task automatic empty_cmp(input int d, input int t, input int s, input int salt, output int bad);
        logic [7:0] b;
        int c;
        bad = 0;
        issue(FN_EMPTY, 1'b0);
        for (int i = 0; i < BYTES; i++) begin
            get_byte(b);
            if (b != pat(d, t, s, i, salt)) bad++;
        end
        wait_done(c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c, c0, bad;
        fn_t f;
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_fn = 3'd0; cmd_drv = 1'b0;
        data_wr = 1'b0; data_in = 8'd0; data_rd = 1'b0;
        drv_media = 2'b11; drv_wprot = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: automatic init after reset
        wait_done(c);
        check(done && st_init_done && err_code == 8'h00 && !xreq, "R1 reset init", err_code, 0);

        // R11 / R2: read-error-code after a clean init
        issue(FN_ECODE, 1'b0);
        wait_done(c);
        check(data_out == 8'h00 && err_code == 8'h00, "R11 code zero", data_out, 0);

        // R3: sector then track handshake
        issue(FN_READ, 1'b0);
        check(xreq && !done, "R3 sector request", xreq, 1);
        put_byte(8'd1);
        check(xreq && !done, "R3 track request", xreq, 1);
        put_byte(8'd1);
        check(!xreq, "R3 request drops", xreq, 0);
        wait_done(c);
        check(err_code == 8'h00, "R3 read ok", err_code, 0);

        // R14 / R8: write every sector of both drives, then read all back
        for (int d = 0; d < 2; d++)
            for (int t = 0; t < TRACKS; t++)
                for (int s = 1; s <= SECTORS; s++) begin
                    fill_pat(d, t, s, 0);
                    f = (d == 1 && s == 2) ? FN_WRDEL : FN_WRITE;
                    sector_rw(f, d, s, t, c);
                    check(err_code == 8'h00 && st_deleted == (f == FN_WRDEL),
                          "R8 write status", {st_deleted, err_code}, (f == FN_WRDEL) ? 256 : 0);
                end
        for (int d = 0; d < 2; d++)
            for (int t = 0; t < TRACKS; t++)
                for (int s = 1; s <= SECTORS; s++) begin
                    sector_rw(FN_READ, d, s, t, c);
                    empty_cmp(d, t, s, 0, bad);
                    check(err_code == 8'h00 && bad == 0, "R14 readback", bad, 0);
                end

        // R4: seek latency scales with distance
        sector_rw(FN_READ, 0, 1, 7, c0);
        sector_rw(FN_READ, 0, 1, 2, c);
        check(c - c0 == STEP * 5, "R4 seek 5 tracks", c - c0, STEP * 5);
        // R5: bad tracks, current track unchanged
        sector_rw(FN_READ, 0, 1, 9, c);
        check(err_code == 8'o040, "R5 track 9", err_code, 8'o040);
        sector_rw(FN_READ, 0, 1, TRACKS, c);
        check(err_code == 8'o040, "R5 track limit", err_code, 8'o040);
        sector_rw(FN_READ, 0, 1, 2, c);
        check(c == c0, "R4 track kept after bad track", c, c0);
        // R6: bad sectors, track still updated
        sector_rw(FN_READ, 0, 0, 4, c);
        check(err_code == 8'o070, "R6 sector 0", err_code, 8'o070);
        sector_rw(FN_READ, 0, 1, 4, c);
        check(c == c0, "R4 track moved before sector check", c, c0);
        sector_rw(FN_READ, 0, SECTORS, 4, c);
        check(err_code == 8'h00, "R6 last sector ok", err_code, 0);
        sector_rw(FN_READ, 0, SECTORS + 1, 4, c);
        check(err_code == 8'o070, "R6 sector above range", err_code, 8'o070);

        // R11: error code read back unchanged
        issue(FN_ECODE, 1'b0);
        wait_done(c);
        check(data_out == 8'o070, "R11 data", data_out, 8'o070);
        check(err_code == 8'o070, "R11 code kept", err_code, 8'o070);

        // R7: write protect and missing media
        drv_wprot = 2'b01;
        fill_pat(0, 3, 2, 77);
        sector_rw(FN_WRITE, 0, 2, 3, c);
        check(err_code == 8'o100 && st_wlock, "R7 write lock", err_code, 8'o100);
        drv_wprot = 2'b00;
        sector_rw(FN_READ, 0, 2, 3, c);
        empty_cmp(0, 3, 2, 0, bad);
        check(bad == 0, "R7 store unchanged", bad, 0);
        drv_media = 2'b01;
        sector_rw(FN_READ, 1, 1, 0, c);
        check(err_code == 8'o110, "R7 no media", err_code, 8'o110);
        drv_media = 2'b11;

        // R12 / R9 / R10: busy command ignored, fill then empty
        issue(FN_FILL, 1'b0);
        issue(FN_NOP, 1'b0);
        check(!done && xreq, "R12 busy command ignored", done, 0);
        for (int i = 0; i < BYTES - 1; i++) put_byte(pat(0, 0, 0, i, 123));
        check(!done && xreq, "R9 request held", xreq, 1);
        put_byte(pat(0, 0, 0, BYTES - 1, 123));
        check(done && !xreq && err_code == 8'h00, "R9 fill complete", done, 1);
        repeat (5) @(negedge clk);
        check(done, "R12 done held", done, 1);
        empty_cmp(0, 0, 0, 123, bad);
        check(bad == 0 && done, "R10 empty order", bad, 0);

        // R13: init command reloads track 1 sector 1 and re-homes drive 0
        fill_pat(0, 1, 1, 200);
        sector_rw(FN_WRITE, 0, 1, 1, c);
        sector_rw(FN_READ, 0, 1, 4, c);
        fill_pat(0, 0, 0, 9);
        issue(FN_INIT, 1'b0);
        wait_done(c);
        check(st_init_done && err_code == 8'h00, "R13 init ok", err_code, 0);
        empty_cmp(0, 1, 1, 200, bad);
        check(bad == 0, "R13 init buffer", bad, 0);
        sector_rw(FN_READ, 0, 1, 1, c);
        check(c == c0, "R13 drive 0 on track 1", c, c0);
        drv_media = 2'b01;
        issue(FN_INIT, 1'b0);
        wait_done(c);
        check(st_init_done && err_code == 8'o020, "R13 drive 1 absent", err_code, 8'o020);
        drv_media = 2'b10;
        issue(FN_INIT, 1'b0);
        wait_done(c);
        check(st_init_done && err_code == 8'o010, "R1 drive 0 absent", err_code, 8'o010);
        drv_media = 2'b11;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule